// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog driven by a coarse tick. A prescaler divides the system clock down to the tick. Software sets a timeout period, releases a halt bit, and then keeps writing the reload register before the count runs out.

If the count runs out once, the block records a first-stage timeout. That timeout can raise a management interrupt, and the counter restarts on its own for a second countdown. If the second countdown also runs out with no reload in between, the block asks for a system reset. A separate no-reboot control bit can veto that request. In that case the block records a blocked-reset status and keeps counting.

A parameter selects one of two period formats. The wide format has a 10-bit period field in a 16-bit register, with a legal range of 2 to 613 ticks. The narrow format has a 6-bit period field in an 8-bit register, with a legal range of 4 to 39 ticks. One tick is meant to be roughly 0.6 s.

The register port is a flat bus: a 3-bit address, 16-bit write data, a write strobe and a width select. When the width select is low, only the low byte is written. Reads are combinational from the address.

Top module: `wdt_top`

## Requirements
- R1: Out of reset the halt bit (control register, address 2, bit 0) reads 1, the no-reboot bit (address 5, bit 0) reads 1, the status register (address 3) reads 0, the counter (address 0) and the period field both hold the mode maximum (613 wide, 39 narrow), and smi_o and reboot_req_o are low.
- R2: The period register is at address 1 and its period field is bits [9:0] in wide mode. Its upper bits are stored and read back unchanged. A write with wide_i low updates only bits [7:0].
- R3: Any write to address 0, whatever its data, loads the counter with the period field, cancels a pending second stage and restarts the prescaler. Reading address 0 returns the counter.
- R4: While running, the counter decrements once every TICK_DIV clocks. A period P set by a reload at clock edge E gives the first expiry at edge E+P*TICK_DIV. The first expiry sets status bit 0 and reloads the counter from the period field.
- R5: While the halt bit is 1, the prescaler and the counter hold their values.
- R6: A second expiry with no reload since the first one sets status bit 1. If the no-reboot bit is 0, it also drives reboot_req_o high for exactly one cycle, and the counter then stays frozen until reset.
- R7: When a second expiry happens while the no-reboot bit is 1, reboot_req_o stays low, status bit 2 (blocked reset) is set, and counting continues.
- R8: A reload write during the second countdown cancels it, so the next expiry counts as a first expiry and asks for no reset.
- R9: Status bits are write-one-to-clear. A 1 in the write data clears the bit and a 0 leaves it unchanged.
- R10: smi_o is high exactly when status bit 0 is set and address 4 has both bit 0 (watchdog interrupt enable) and bit 1 (global interrupt enable) set.
- R11: The no-reboot bit in the general control register (address 5, bit 0) is writable and reads back the value written.
- R12: In narrow mode the period register is 8 bits wide. Bits [15:8] read 0, and the period field is bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| wide_i | input | 1 | 1: 16-bit write, 0: low byte only |
| rdata_o | output | 16 | Read data for addr_i |
| smi_o | output | 1 | Management interrupt request, level |
| reboot_req_o | output | 1 | System reset request, one-cycle pulse |

## Verification
On every cycle the assertions check the following:
- The counter holds still while halted.
- A reload write lands the period in the counter.
- The reset request is a single-cycle pulse that never appears while the no-reboot bit is set.
- The counter freezes once a reset has been requested.
- The interrupt never rises without a first-stage timeout behind it.

Some behaviours only the bench scenarios can show:
- The exact expiry cycle for a given period and divide ratio.
- That a reload in the second countdown really cancels the reset.
- The byte-lane and narrow-mode register masking.
- That the blocked-reset status appears only on a second expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 3'd0,
        A_PERIOD = 3'd1,
        A_CTRL   = 3'd2,
        A_STATUS = 3'd3,
        A_SMIEN  = 3'd4,
        A_GENCTL = 3'd5
    } reg_addr_e;

    // status bit positions
    localparam int STS_FIRST  = 0;
    localparam int STS_SECOND = 1;
    localparam int STS_BLOCK  = 2;
    localparam int STS_W      = 3;

    // control and enable bit positions
    localparam int CTRL_HALT  = 0;
    localparam int EN_WDT     = 0;
    localparam int EN_GLOBAL  = 1;
    localparam int GEN_NOREB  = 0;

    localparam int WIDE_PW    = 10;
    localparam int NARROW_PW  = 6;
    localparam int WIDE_PMAX  = 613;
    localparam int NARROW_PMAX = 39;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    typedef struct packed {
        logic [DW-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pre = '0;
        end else if (run_i) begin
            if (st_q.pre == LAST) st_d.pre = '0;
            else                  st_d.pre = st_q.pre + DW'(1);
        end
    end

    assign tick_o = run_i && !clr_i && (st_q.pre == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int PW   = 10,
    parameter int PMAX = 613
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          reload_i,
    input  logic [PW-1:0] period_i,
    input  logic          noreb_i,
    output logic [PW-1:0] cnt_o,
    output logic          fired_o,
    output logic          reboot_o,
    output logic          set_first_o,
    output logic          set_second_o,
    output logic          set_block_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          stage2;
        logic          fired;
        logic          reboot;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic first_d, second_d, block_d;

    always_comb begin
        st_d        = st_q;
        st_d.reboot = 1'b0;
        first_d     = 1'b0;
        second_d    = 1'b0;
        block_d     = 1'b0;
        if (!st_q.fired) begin
            if (reload_i) begin
                st_d.cnt    = period_i;
                st_d.stage2 = 1'b0;
            end else if (tick_i) begin
                if (st_q.cnt <= PW'(1)) begin
                    first_d  = 1'b1;
                    st_d.cnt = period_i;
                    if (st_q.stage2) begin
                        second_d = 1'b1;
                        if (noreb_i) begin
                            block_d = 1'b1;
                        end else begin
                            st_d.reboot = 1'b1;
                            st_d.fired  = 1'b1;
                        end
                    end else begin
                        st_d.stage2 = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= PW'(PMAX);
            st_q.stage2 <= 1'b0;
            st_q.fired  <= 1'b0;
            st_q.reboot <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o        = st_q.cnt;
    assign fired_o      = st_q.fired;
    assign reboot_o     = st_q.reboot;
    assign set_first_o  = first_d;
    assign set_second_o = second_d;
    assign set_block_o  = block_d;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    parameter int PW   = 10,
    parameter int PMAX = 613
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              wide_i,
    input  logic [PW-1:0]     cnt_i,
    input  logic              set_first_i,
    input  logic              set_second_i,
    input  logic              set_block_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              reload_wr_o,
    output logic [PW-1:0]     period_o,
    output logic              halt_o,
    output logic              noreb_o,
    output logic              wdt_en_o,
    output logic              glb_en_o,
    output logic              first_sts_o
);
    localparam logic [DATA_W-1:0] PER_MASK = WIDE ? 16'hFFFF : 16'h00FF;

    typedef struct packed {
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] smien;
        logic [DATA_W-1:0] gen;
        logic [STS_W-1:0]  sts;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [DATA_W-1:0] lane;

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [DATA_W-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    assign lane = wide_i ? 16'hFFFF : 16'h00FF;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            case (addr_i)
                A_PERIOD: st_d.period = merge(st_q.period, wdata_i, lane) & PER_MASK;
                A_CTRL:   st_d.ctrl   = merge(st_q.ctrl, wdata_i, lane);
                A_SMIEN:  st_d.smien  = merge(st_q.smien, wdata_i, lane);
                A_GENCTL: st_d.gen    = merge(st_q.gen, wdata_i, lane);
                A_STATUS: st_d.sts    = st_q.sts & ~wdata_i[STS_W-1:0];
                default:  ;
            endcase
        end
        if (set_first_i)  st_d.sts[STS_FIRST]  = 1'b1;
        if (set_second_i) st_d.sts[STS_SECOND] = 1'b1;
        if (set_block_i)  st_d.sts[STS_BLOCK]  = 1'b1;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_RELOAD: rdata_o = DATA_W'(cnt_i);
            A_PERIOD: rdata_o = st_q.period;
            A_CTRL:   rdata_o = st_q.ctrl;
            A_STATUS: rdata_o = DATA_W'(st_q.sts);
            A_SMIEN:  rdata_o = st_q.smien;
            A_GENCTL: rdata_o = st_q.gen;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.period <= DATA_W'(PMAX);
            st_q.ctrl   <= DATA_W'(1) << CTRL_HALT;
            st_q.smien  <= '0;
            st_q.gen    <= DATA_W'(1) << GEN_NOREB;
            st_q.sts    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_wr_o = we_i && (addr_i == A_RELOAD);
    assign period_o    = st_q.period[PW-1:0];
    assign halt_o      = st_q.ctrl[CTRL_HALT];
    assign noreb_o     = st_q.gen[GEN_NOREB];
    assign wdt_en_o    = st_q.smien[EN_WDT];
    assign glb_en_o    = st_q.smien[EN_GLOBAL];
    assign first_sts_o = st_q.sts[STS_FIRST];
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter bit WIDE_MODE = 1'b1,
    parameter int TICK_DIV  = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [2:0]  addr_i,
    input  logic [15:0] wdata_i,
    input  logic        we_i,
    input  logic        wide_i,
    output logic [15:0] rdata_o,
    output logic        smi_o,
    output logic        reboot_req_o
);
    localparam int PW   = WIDE_MODE ? WIDE_PW : NARROW_PW;
    localparam int PMAX = WIDE_MODE ? WIDE_PMAX : NARROW_PMAX;

    logic          tick, reload_wr, halt, noreb, wdt_en, glb_en, first_sts;
    logic          fired, set_first, set_second, set_block;
    logic [PW-1:0] period_fld, cnt;

    wdt_regs #(.WIDE(WIDE_MODE), .PW(PW), .PMAX(PMAX)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .we_i         (we_i),
        .wide_i       (wide_i),
        .cnt_i        (cnt),
        .set_first_i  (set_first),
        .set_second_i (set_second),
        .set_block_i  (set_block),
        .rdata_o      (rdata_o),
        .reload_wr_o  (reload_wr),
        .period_o     (period_fld),
        .halt_o       (halt),
        .noreb_o      (noreb),
        .wdt_en_o     (wdt_en),
        .glb_en_o     (glb_en),
        .first_sts_o  (first_sts)
    );

    wdt_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (!halt && !fired),
        .clr_i  (reload_wr),
        .tick_o (tick)
    );

    wdt_counter #(.PW(PW), .PMAX(PMAX)) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .reload_i     (reload_wr),
        .period_i     (period_fld),
        .noreb_i      (noreb),
        .cnt_o        (cnt),
        .fired_o      (fired),
        .reboot_o     (reboot_req_o),
        .set_first_o  (set_first),
        .set_second_o (set_second),
        .set_block_o  (set_block)
    );

    assign smi_o = first_sts && wdt_en && glb_en;
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk #(
    parameter int PW = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [PW-1:0] cnt,
    input logic [PW-1:0] period_fld,
    input logic          halt,
    input logic          noreb,
    input logic          fired,
    input logic          reload_wr,
    input logic          first_sts,
    input logic          smi_o,
    input logic          reboot_req_o
);
    // R5
    halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt && !reload_wr) |=> $stable(cnt));

    // R3
    reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_wr && !fired) |=> (cnt == $past(period_fld)));

    // R6
    reboot_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reboot_req_o |=> !reboot_req_o);

    // R6
    frozen_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fired |=> $stable(cnt));

    // R7
    noreb_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reboot_req_o |-> !$past(noreb));

    // R10
    smi_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smi_o |-> first_sts);
endmodule

bind wdt_top wdt_top_chk #(.PW(PW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt          (cnt),
    .period_fld   (period_fld),
    .halt         (halt),
    .noreb        (noreb),
    .fired        (fired),
    .reload_wr    (reload_wr),
    .first_sts    (first_sts),
    .smi_o        (smi_o),
    .reboot_req_o (reboot_req_o)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        we_w = 1'b0, we_l = 1'b0, wide = 1'b1;
    logic [15:0] rd_w, rd_l;
    logic        smi_w, smi_l, reb_w, reb_l;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top #(.WIDE_MODE(1'b1), .TICK_DIV(DIV)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .we_i(we_w), .wide_i(wide), .rdata_o(rd_w), .smi_o(smi_w),
        .reboot_req_o(reb_w));

    wdt_top #(.WIDE_MODE(1'b0), .TICK_DIV(DIV)) u_dut_leg (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .we_i(we_l), .wide_i(wide), .rdata_o(rd_l), .smi_o(smi_l),
        .reboot_req_o(reb_l));

    typedef struct packed {
        logic [2:0]  a;
        logic        w;
        logic [15:0] d;
        logic [15:0] e;
    } vec_t;

    localparam vec_t VEC [0:9] = '{
        '{3'd1, 1'b1, 16'hFC05, 16'hFC05},  // R2 full write
        '{3'd1, 1'b0, 16'h1233, 16'hFC33},  // R2 low byte only
        '{3'd2, 1'b1, 16'h0001, 16'h0001},
        '{3'd2, 1'b1, 16'hA5A1, 16'hA5A1},
        '{3'd4, 1'b1, 16'h0003, 16'h0003},
        '{3'd4, 1'b1, 16'h0000, 16'h0000},
        '{3'd5, 1'b1, 16'h0000, 16'h0000},  // R11
        '{3'd5, 1'b1, 16'h0001, 16'h0001},  // R11
        '{3'd0, 1'b1, 16'hBEEF, 16'h0033},  // R3 reload, count readback
        '{3'd3, 1'b1, 16'hFFFF, 16'h0000}   // R9
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit leg, input logic [2:0] a, input logic [15:0] d, input bit w);
        @(negedge clk);
        addr = a; wdata = d; wide = w;
        if (leg) we_l = 1'b1; else we_w = 1'b1;
        @(negedge clk);
        we_l = 1'b0; we_w = 1'b0;
    endtask

    task automatic rd(input bit leg, input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = leg ? rd_l : rd_w;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 3'd1, v); check("R1 period wide", v, 16'd613);
        rd(0, 3'd0, v); check("R1 count wide", v, 16'd613);
        rd(0, 3'd2, v); check("R1 halt", v, 16'h0001);
        rd(0, 3'd5, v); check("R1 noreboot", v, 16'h0001);
        rd(0, 3'd3, v); check("R1 status", v, 16'h0000);
        check("R1 outputs", {14'd0, smi_w, reb_w}, 16'h0000);
        rd(1, 3'd1, v); check("R1 R12 period narrow", v, 16'd39);

        // R5 halted after reset
        repeat (40) @(negedge clk);
        rd(0, 3'd0, v); check("R5 count held", v, 16'd613);

        // R12 narrow mode
        wr(1, 3'd1, 16'hFFC4, 1'b1);
        rd(1, 3'd1, v); check("R12 narrow upper zero", v, 16'h00C4);
        wr(1, 3'd0, 16'h0000, 1'b1);
        rd(1, 3'd0, v); check("R12 narrow reload", v, 16'h0004);
        wr(1, 3'd2, 16'h0000, 1'b1);
        repeat (15) @(negedge clk);
        rd(1, 3'd3, v); check("R12 before expiry", v, 16'h0000);
        repeat (1) @(negedge clk);
        rd(1, 3'd3, v); check("R12 R4 narrow expiry", v, 16'h0001);

        // vector table on the wide instance
        for (int i = 0; i < 10; i++) begin
            wr(0, VEC[i].a, VEC[i].d, VEC[i].w);
            rd(0, VEC[i].a, v);
            check($sformatf("R2 R3 R9 R11 vector %0d", i), v, VEC[i].e);
        end

        // R4 R7 run with no-reboot set
        wr(0, 3'd1, 16'h0003, 1'b1);
        wr(0, 3'd0, 16'h0001, 1'b1);
        rd(0, 3'd0, v); check("R3 reload period", v, 16'd3);
        wr(0, 3'd2, 16'h0000, 1'b1);
        repeat (4) @(negedge clk);
        rd(0, 3'd0, v); check("R4 one tick", v, 16'd2);
        repeat (7) @(negedge clk);
        rd(0, 3'd3, v); check("R4 before first", v, 16'h0000);
        repeat (1) @(negedge clk);
        rd(0, 3'd3, v); check("R4 first expiry", v, 16'h0001);
        rd(0, 3'd0, v); check("R4 auto reload", v, 16'd3);
        repeat (11) @(negedge clk);
        rd(0, 3'd3, v); check("R7 before second", v, 16'h0001);
        repeat (1) @(negedge clk);
        rd(0, 3'd3, v); check("R7 blocked status", v, 16'h0007);
        check("R7 no reboot", {15'd0, reb_w}, 16'h0000);

        // R5 halt mid-run
        wr(0, 3'd2, 16'h0001, 1'b1);
        rd(0, 3'd0, v);
        repeat (30) @(negedge clk);
        rd(0, 3'd0, v2); check("R5 halt mid-run", v2, v);

        // R10 interrupt gating
        check("R10 no enables", {15'd0, smi_w}, 16'h0000);
        wr(0, 3'd4, 16'h0001, 1'b1);
        check("R10 wdt enable only", {15'd0, smi_w}, 16'h0000);
        wr(0, 3'd4, 16'h0002, 1'b1);
        check("R10 global only", {15'd0, smi_w}, 16'h0000);
        wr(0, 3'd4, 16'h0003, 1'b1);
        check("R10 both", {15'd0, smi_w}, 16'h0001);

        // R9 write-one-to-clear
        wr(0, 3'd3, 16'h0002, 1'b1);
        rd(0, 3'd3, v); check("R9 clear bit1", v, 16'h0005);
        wr(0, 3'd3, 16'h0001, 1'b1);
        rd(0, 3'd3, v); check("R9 clear bit0", v, 16'h0004);
        check("R10 status cleared", {15'd0, smi_w}, 16'h0000);
        wr(0, 3'd3, 16'h0004, 1'b1);
        rd(0, 3'd3, v); check("R9 clear bit2", v, 16'h0000);

        // R8 R6 reload cancels second stage, then real reset request
        wr(0, 3'd5, 16'h0000, 1'b1);
        rd(0, 3'd5, v); check("R11 noreboot cleared", v, 16'h0000);
        wr(0, 3'd0, 16'h0000, 1'b1);
        wr(0, 3'd2, 16'h0000, 1'b1);
        repeat (12) @(negedge clk);
        rd(0, 3'd3, v); check("R4 first expiry again", v, 16'h0001);
        repeat (5) @(negedge clk);
        wr(0, 3'd0, 16'h0000, 1'b1);
        seen = 1'b0;
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            if (i == 12) begin
                rd(0, 3'd3, v); check("R8 expiry after reload is first", v, 16'h0001);
            end
            if (i < 24 && reb_w) seen = 1'b1;
        end
        check("R8 no early reboot", {15'd0, seen}, 16'h0000);
        check("R6 reboot pulse", {15'd0, reb_w}, 16'h0001);
        rd(0, 3'd3, v); check("R6 second status", v, 16'h0003);
        @(negedge clk);
        check("R6 pulse one cycle", {15'd0, reb_w}, 16'h0000);
        rd(0, 3'd0, v);
        repeat (20) @(negedge clk);
        rd(0, 3'd0, v2); check("R6 frozen", v2, v);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule